// File: doc/BRIEF.md
# Boot Flash Access Controller

This controller sits between a CPU and an on-chip program flash that is divided two ways. The first division separates a boot-code section at the top of the address space from the application section below it. A 2-bit configuration input sets the size of the boot section. The second division separates a lower region, which can still be read while an operation runs elsewhere, from an upper region, which cannot. The upper region always covers the largest possible boot section.

The CPU issues read, page-program and page-erase requests. Each request carries the address of the instruction that issued it. Program and erase are honoured only when that instruction lies in the boot section. Two lock fields, one for each section, restrict writes and cross-section reads. Misaligned program or erase addresses are reported and start nothing.

Accepted program and erase requests are passed to a flash macro. The macro reports its progress on a busy line. The controller stalls the CPU for the whole operation when the target lies in the upper region. When the target lies in the lower region, reads of the upper region carry on and reads of the lower region return a busy flag instead of data.

Top module: `boot_flash_ctrl`

## Requirements
- R1: `boot_sz` sets the boot section size to 4 KiB shifted left by its value (00: 4 KiB, 01: 8 KiB, 10: 16 KiB, 11: 32 KiB). The section ends at the top of the 64 KiB byte space, so an address is in it when it is at or above 65536 minus the size.
- R2: A program (`cpu_op`=01) or erase (`cpu_op`=10) whose `cpu_pc` lies outside the boot section is answered with `cpu_deny`, and `fl_start` stays low.
- R3: A program address must be a multiple of 8 and an erase address must be a multiple of 4096. `cpu_op`=11 is always an error. A violation answers with `cpu_err` and starts nothing, and this error takes precedence over any denial.
- R4: The lock field of the target section allows writes only at 11. The values 10, 01 and 00 deny program and erase requests aimed at that section. The field used is `lock_boot` when the target is in the boot section and `lock_app` otherwise.
- R5: A lock field of 00 or 01 denies reads of its section by code running in the other section. Reads from code in the same section, and reads under lock values 10 or 11, are allowed.
- R6: After a program or erase starts with a target at or above 32768, `cpu_stall` is high from the next cycle until the cycle after `fl_busy` falls. No request of any kind is accepted during that time.
- R7: While an operation targeting an address below 32768 is active, a read below 32768 answers with `cpu_rbusy`. A read at or above 32768 answers with `cpu_rvalid` and the flash data, without a stall.
- R8: A program or erase request made while any operation is active is held with `cpu_stall` until the operation ends, and is then accepted.
- R9: Every accepted request produces exactly one of `cpu_rvalid`, `cpu_rbusy`, `cpu_ack`, `cpu_err` or `cpu_deny` in the following cycle. `cpu_rdata` then holds the flash word at the read address. `cpu_ack` marks a started operation.
- R10: During reset all response outputs, `cpu_stall` and `fl_start` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_sz | input | 2 | Boot section size setting |
| lock_app | input | 2 | Lock field for the application section |
| lock_boot | input | 2 | Lock field for the boot section |
| cpu_req | input | 1 | Request valid |
| cpu_op | input | 2 | 00 read, 01 program, 10 erase, 11 invalid |
| cpu_addr | input | ADDR_W | Target byte address |
| cpu_pc | input | ADDR_W | Address of the issuing instruction |
| cpu_wdata | input | DATA_W | Program data |
| cpu_stall | output | 1 | Request not accepted this cycle |
| cpu_rvalid | output | 1 | Read data valid |
| cpu_rbusy | output | 1 | Read refused, region busy |
| cpu_ack | output | 1 | Program or erase started |
| cpu_err | output | 1 | Alignment or opcode error |
| cpu_deny | output | 1 | Protection refusal |
| cpu_rdata | output | DATA_W | Read data |
| fl_start | output | 1 | Start a flash operation |
| fl_erase | output | 1 | Started operation is an erase |
| fl_addr | output | ADDR_W | Operation address |
| fl_wdata | output | DATA_W | Program data to the macro |
| fl_raddr | output | ADDR_W | Read address to the macro |
| fl_rdata | input | DATA_W | Read data from the macro, combinational |
| fl_busy | input | 1 | Macro busy, rising the cycle after a start |

## Verification
The assertions check on every cycle that no two response flags ever coincide, and that each start is followed by an acknowledge. They also check that a start never overlaps a busy macro, that started addresses are aligned and issued from boot code, and that starting an upper-region operation raises the stall. The exact length of a stall, the choice between stalling and returning the busy flag for reads, the size boundaries chosen by `boot_sz` and the lock decoding can only be shown by the bench's scenarios. In those scenarios the bench compares response codes, read data and counted stall cycles against values it computes itself.

// File: rtl/boot_flash_ctrl.sv
`timescale 1ns/1ps
module boot_flash_ctrl #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 64,
  parameter int ERASE_B   = 4096,
  parameter int WRITE_B   = 8,
  parameter int NRWW_BASE = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        boot_sz,
  input  logic [1:0]        lock_app,
  input  logic [1:0]        lock_boot,
  input  logic              cpu_req,
  input  logic [1:0]        cpu_op,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [ADDR_W-1:0] cpu_pc,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_stall,
  output logic              cpu_rvalid,
  output logic              cpu_rbusy,
  output logic              cpu_ack,
  output logic              cpu_err,
  output logic              cpu_deny,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              fl_start,
  output logic              fl_erase,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0] fl_wdata,
  output logic [ADDR_W-1:0] fl_raddr,
  input  logic [DATA_W-1:0] fl_rdata,
  input  logic              fl_busy
);
  localparam int EW = $clog2(ERASE_B);
  localparam int WW = $clog2(WRITE_B);
  localparam logic [ADDR_W-1:0] ONES   = '1;
  localparam logic [ADDR_W-1:0] UPPER  = ADDR_W'(NRWW_BASE);

  logic [ADDR_W-1:0] bmask;
  logic t_boot, p_boot, t_upper, is_rd, is_prog, misal;
  logic [1:0] t_lock;
  logic wr_ok, rd_ok, go, op_busy, hold;
  logic start_q, upper_q;

  assign bmask   = ONES << (EW + int'(boot_sz));
  assign t_boot  = (cpu_addr & bmask) == bmask;
  assign p_boot  = (cpu_pc & bmask) == bmask;
  assign t_upper = cpu_addr >= UPPER;
  assign t_lock  = t_boot ? lock_boot : lock_app;

  assign is_rd   = cpu_op == 2'b00;
  assign is_prog = cpu_op == 2'b01 || cpu_op == 2'b10;
  assign misal   = (cpu_op == 2'b01) ? |cpu_addr[WW-1:0] :
                   (cpu_op == 2'b10) ? |cpu_addr[EW-1:0] :
                   (cpu_op == 2'b11);

  assign wr_ok = p_boot && t_lock == 2'b11;
  assign rd_ok = t_lock[1] || (t_boot == p_boot);

  assign op_busy   = start_q | fl_busy;
  assign hold      = op_busy & upper_q;
  assign cpu_stall = hold | (cpu_req & is_prog & op_busy);
  assign go        = cpu_req & ~cpu_stall;

  assign fl_start = go & is_prog & ~misal & wr_ok;
  assign fl_erase = cpu_op == 2'b10;
  assign fl_addr  = cpu_addr;
  assign fl_wdata = cpu_wdata;
  assign fl_raddr = cpu_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q    <= 1'b0;
      upper_q    <= 1'b0;
      cpu_rvalid <= 1'b0;
      cpu_rbusy  <= 1'b0;
      cpu_ack    <= 1'b0;
      cpu_err    <= 1'b0;
      cpu_deny   <= 1'b0;
      cpu_rdata  <= '0;
    end else begin
      start_q    <= fl_start;
      if (fl_start) upper_q <= t_upper;
      cpu_rvalid <= go & is_rd & rd_ok & ~(op_busy & ~t_upper);
      cpu_rbusy  <= go & is_rd & rd_ok & op_busy & ~t_upper;
      cpu_ack    <= fl_start;
      cpu_err    <= go & misal;
      cpu_deny   <= go & ~misal & (is_prog ? ~wr_ok : ~rd_ok);
      if (go & is_rd) cpu_rdata <= fl_rdata;
    end
  end
endmodule

// File: rtl/boot_flash_ctrl_chk.sv
`timescale 1ns/1ps
module boot_flash_ctrl_chk #(
  parameter int ADDR_W    = 16,
  parameter int ERASE_B   = 4096,
  parameter int WRITE_B   = 8,
  parameter int NRWW_BASE = 32768
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        boot_sz,
  input logic [ADDR_W-1:0] cpu_pc,
  input logic              cpu_stall,
  input logic              cpu_rvalid,
  input logic              cpu_rbusy,
  input logic              cpu_ack,
  input logic              cpu_err,
  input logic              cpu_deny,
  input logic              fl_start,
  input logic              fl_erase,
  input logic [ADDR_W-1:0] fl_addr,
  input logic              fl_busy
);
  localparam int EW = $clog2(ERASE_B);
  localparam int WW = $clog2(WRITE_B);
  logic [ADDR_W:0] base;
  assign base = (ADDR_W+1)'(1 << ADDR_W) - ((ADDR_W+1)'(ERASE_B) << boot_sz);

  a_r9_single_response: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cpu_rvalid, cpu_rbusy, cpu_ack, cpu_err, cpu_deny}));
  a_r9_start_acked: assert property (@(posedge clk) disable iff (!rst_n)
    fl_start |=> cpu_ack);
  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    fl_start |-> !fl_busy);
  a_r2_from_boot: assert property (@(posedge clk) disable iff (!rst_n)
    fl_start |-> ({1'b0, cpu_pc} >= base));
  a_r3_prog_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_start && !fl_erase) |-> (fl_addr[WW-1:0] == '0));
  a_r3_erase_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_start && fl_erase) |-> (fl_addr[EW-1:0] == '0));
  a_r6_upper_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_start && fl_addr >= ADDR_W'(NRWW_BASE)) |=> cpu_stall);
  a_r6_no_start_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall |-> !fl_start);
endmodule

bind boot_flash_ctrl boot_flash_ctrl_chk #(
  .ADDR_W(ADDR_W), .ERASE_B(ERASE_B), .WRITE_B(WRITE_B), .NRWW_BASE(NRWW_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .boot_sz(boot_sz), .cpu_pc(cpu_pc),
  .cpu_stall(cpu_stall), .cpu_rvalid(cpu_rvalid), .cpu_rbusy(cpu_rbusy),
  .cpu_ack(cpu_ack), .cpu_err(cpu_err), .cpu_deny(cpu_deny),
  .fl_start(fl_start), .fl_erase(fl_erase), .fl_addr(fl_addr), .fl_busy(fl_busy)
);

// File: tb/boot_flash_ctrl_bench.sv
`timescale 1ns/1ps
module boot_flash_ctrl_bench;
  localparam int CLK_P  = 10;
  localparam int WR_CYC = 5;
  localparam int ER_CYC = 9;

  logic clk = 0, rst_n = 0;
  logic [1:0] boot_sz = 0, lock_app = 2'b11, lock_boot = 2'b11;
  logic cpu_req = 0;
  logic [1:0] cpu_op = 0;
  logic [15:0] cpu_addr = 0, cpu_pc = 0;
  logic [63:0] cpu_wdata = 0;
  logic cpu_stall, cpu_rvalid, cpu_rbusy, cpu_ack, cpu_err, cpu_deny;
  logic [63:0] cpu_rdata, fl_wdata, fl_rdata;
  logic fl_start, fl_erase, fl_busy;
  logic [15:0] fl_addr, fl_raddr;
  int cnt;
  int n_cmp = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  boot_flash_ctrl u_boot_flash_ctrl (.*);

  function automatic logic [63:0] fdata(input logic [15:0] a);
    return {a, ~a, a ^ 16'h5a5a, a + 16'h1234};
  endfunction
  assign fl_rdata = fdata(fl_raddr);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= 0;
    else if (fl_start) cnt <= fl_erase ? ER_CYC : WR_CYC;
    else if (cnt != 0) cnt <= cnt - 1;
  end
  assign fl_busy = cnt != 0;

  function automatic bit in_b(input int a, input int sz);
    return a >= 65536 - (4096 << sz);
  endfunction

  // codes: 0 rvalid, 1 rbusy, 2 ack, 3 err, 4 deny
  function automatic int exp_code(input int op, input int a, input int pc,
      input int sz, input logic [1:0] la, input logic [1:0] lb, input bit rww_busy);
    bit tb, pb; logic [1:0] lk;
    tb = in_b(a, sz); pb = in_b(pc, sz); lk = tb ? lb : la;
    if (op == 3 || (op == 1 && a % 8 != 0) || (op == 2 && a % 4096 != 0)) return 3;
    if (op == 0) begin
      if (lk == 2'b11 || lk == 2'b10 || tb == pb) return (rww_busy && a < 32768) ? 1 : 0;
      return 4;
    end
    return (pb && lk == 2'b11) ? 2 : 4;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int   r_stalls, r_code;
  logic [63:0] r_data;
  logic r_start;
  logic [15:0] r_saddr;

  task automatic issue(input int op, input int a, input int pc, input logic [63:0] wd);
    cpu_req = 1; cpu_op = 2'(op); cpu_addr = 16'(a); cpu_pc = 16'(pc); cpu_wdata = wd;
    #1;
    r_stalls = 0;
    while (cpu_stall) begin
      r_stalls++;
      @(negedge clk); #1;
    end
    r_start = fl_start; r_saddr = fl_addr;
    @(posedge clk);
    @(negedge clk);
    cpu_req = 0;
    r_code = cpu_rvalid ? 0 : cpu_rbusy ? 1 : cpu_ack ? 2 : cpu_err ? 3 : cpu_deny ? 4 : 7;
    if ((cpu_rvalid + cpu_rbusy + cpu_ack + cpu_err + cpu_deny) > 1) r_code = 8;
    r_data = cpu_rdata;
  endtask

  task automatic idle();
    while (fl_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_op(input string tag, input int op, input int a, input int pc, input int ec);
    issue(op, a, pc, 64'hfeed_0000_0000_0000 | 64'(a));
    chk(r_code == ec, tag, r_code, ec);
    chk(r_start == (ec == 2), {tag, " start"}, r_start, ec == 2);
    if (ec == 0) chk(r_data == fdata(16'(a)), {tag, " data"}, r_data, fdata(16'(a)));
    if (ec == 2) chk(r_saddr == 16'(a), {tag, " addr"}, r_saddr, a);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R10
    chk({cpu_stall, cpu_rvalid, cpu_rbusy, cpu_ack, cpu_err, cpu_deny, fl_start} == 0,
        "R10 reset outputs", {cpu_stall, cpu_ack, fl_start}, 0);
    rst_n = 1;
    @(negedge clk);

    // R1 boundaries
    for (int s = 0; s < 4; s++) begin
      boot_sz = 2'(s);
      check_op("R1 pc at boot base", 1, 16'h0100, 65536 - (4096 << s), 2); idle();
      check_op("R1 pc below boot base", 1, 16'h0100, 65535 - (4096 << s), 4); idle();
    end

    // R2 / R3
    boot_sz = 0;
    check_op("R2 write from app code", 1, 16'h0200, 16'h1000, 4); idle();
    check_op("R3 misaligned write", 1, 16'h1004, 16'hf100, 3); idle();
    check_op("R3 misaligned erase beats deny", 2, 16'h1800, 16'h0100, 3); idle();
    check_op("R3 invalid op", 3, 16'h1000, 16'hf100, 3); idle();
    check_op("R3 aligned erase", 2, 16'h2000, 16'hf100, 2); idle();

    // R4
    lock_app = 2'b10; check_op("R4 app lock 10", 1, 16'h0300, 16'hf100, 4); idle();
    lock_app = 2'b01; check_op("R4 app lock 01", 2, 16'h3000, 16'hf100, 4); idle();
    lock_app = 2'b11; lock_boot = 2'b10;
    check_op("R4 boot lock 10", 1, 16'hf008, 16'hf100, 4); idle();
    check_op("R4 app write allowed", 1, 16'h0308, 16'hf100, 2); idle();

    // R5
    lock_boot = 2'b00;
    check_op("R5 cross read of boot denied", 0, 16'hf010, 16'h0100, 4);
    check_op("R5 same-section read of boot", 0, 16'hf010, 16'hf200, 0);
    lock_boot = 2'b11; lock_app = 2'b10;
    check_op("R5 lock 10 allows cross read", 0, 16'h0040, 16'hf200, 0);
    lock_app = 2'b01;
    check_op("R5 lock 01 denies cross read", 0, 16'h0040, 16'hf200, 4);
    lock_app = 2'b11;

    // R6: upper-region write stalls a following read
    boot_sz = 2'b11;
    check_op("R6 upper write", 1, 16'h8008, 16'hff00, 2);
    check_op("R6 read after stall", 0, 16'h0010, 16'hff00, 0);
    chk(r_stalls == WR_CYC, "R6 stall cycles", r_stalls, WR_CYC);
    idle();

    // R7 / R8: lower-region erase
    boot_sz = 0;
    check_op("R7 lower erase", 2, 16'h3000, 16'hf100, 2);
    chk(r_stalls == 0, "R7 no stall on start", r_stalls, 0);
    check_op("R7 read busy region", 0, 16'h3010, 16'hf100, 1);
    chk(r_stalls == 0, "R7 busy read not stalled", r_stalls, 0);
    check_op("R7 read other region", 0, 16'h9000, 16'hf100, 0);
    chk(r_stalls == 0, "R7 other read not stalled", r_stalls, 0);
    check_op("R8 second write held", 1, 16'h0100, 16'hf100, 2);
    chk(r_stalls == ER_CYC - 2, "R8 held cycles", r_stalls, ER_CYC - 2);
    idle();

    // random, flash idle
    for (int i = 0; i < 400; i++) begin
      int op, a, pc, sz, ec;
      sz = $urandom % 4; boot_sz = 2'(sz);
      lock_app = 2'($urandom); lock_boot = 2'($urandom);
      if ($urandom % 3 != 0) lock_app = 2'b11;
      if ($urandom % 3 != 0) lock_boot = 2'b11;
      op = ($urandom % 8 == 0) ? 3 : $urandom % 3;
      a = $urandom % 65536;
      if (op == 1 && $urandom % 4 != 0) a = a & 32'hfff8;
      if (op == 2 && $urandom % 4 != 0) a = a & 32'hf000;
      pc = ($urandom % 4 != 0) ? 65535 - ($urandom % (4096 << sz)) : $urandom % 65536;
      ec = exp_code(op, a, pc, sz, lock_app, lock_boot, 1'b0);
      check_op($sformatf("R9 random op%0d", op), op, a, pc, ec);
      idle();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule